// File: doc/BRIEF.md
# Crystal Time-Trimming Prescaler

This block divides an oscillator tick stream down to a one-second count-up strobe, a half-second strobe and a 1 Hz phase level. It supports two crystal rates. With the 32.768 kHz setting each second is split into two equal halves. With the 32.000 kHz setting the low half is 15,872 ticks and the high half is 16,128 ticks, so the phase level is low for 0.496 s and high for 0.504 s.

A signed 7-bit trim code corrects the crystal's frequency error. The correction is applied to one second out of every twenty, the last second of each window, and `win_o` flags that second while it runs. Each trim step moves the corrected second by two oscillator ticks. A positive code shortens the second so the clock gains. A negative code lengthens it so the clock loses.

A stop detector runs on the always-running system clock. It counts system cycles that pass without an oscillator tick. When too many pass, it sets a sticky halt flag. The flag is also set at reset, which marks a start from power-off. While the flag is set, the trim code and the crystal select are forced to zero. A control write clears the flag.

Top module: `trim_prescaler`

## Requirements
- R1: After reset, `halt_o` is 1, while `sec_o`, `hz2_o`, `hz1_o` and `win_o` are 0.
- R2: When `xtal_sel_i`=0 (32.768 kHz), an uncorrected second lasts 2×HALF_A oscillator ticks. `hz1_o` is low for the first HALF_A ticks and high for the next HALF_A ticks.
- R3: When `xtal_sel_i`=1 (32.000 kHz), `hz1_o` is low for LO_B ticks and high for HI_B ticks, and an uncorrected second lasts LO_B+HI_B ticks.
- R4: `hz2_o` pulses for one cycle at every half-second boundary, which is two pulses per second. `sec_o` pulses for one cycle at the end of each high half, together with an `hz2_o` pulse.
- R5: Out of every WIN consecutive seconds, exactly one is corrected, the last second of the window. `win_o` is 1 throughout that second, including the cycle of its `sec_o` pulse.
- R6: The corrected second lasts its nominal length minus STEP×trim ticks, where `trim_i` is two's-complement. A positive code shortens the second, a negative code lengthens it, and zero leaves it unchanged.
- R7: Seconds outside the correction slot keep their nominal length whatever the trim code.
- R8: When `osc_tick_i` stays low for STOP_TO consecutive clock cycles, `halt_o` is set. It stays set after ticks resume, until a `ctrl_wr_i` pulse clears it.
- R9: While `halt_o` is 1, the trim code and the crystal select are treated as 0.
- R10: The divider advances only on cycles in which `osc_tick_i` is high, so the length of a second in clock cycles scales with the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | One-cycle enable per oscillator period |
| xtal_sel_i | input | 1 | Crystal select: 0 = 32.768 kHz, 1 = 32.000 kHz |
| trim_i | input | TRIM_W | Signed trim code |
| ctrl_wr_i | input | 1 | Control write pulse that clears the halt flag |
| sec_o | output | 1 | One-cycle seconds count-up strobe |
| hz2_o | output | 1 | One-cycle half-second strobe |
| hz1_o | output | 1 | 1 Hz phase level (low half first) |
| win_o | output | 1 | High during the corrected second of each window |
| halt_o | output | 1 | Sticky oscillator-halt flag |

## Verification
The `sec_o` and `hz2_o` strobes rise one cycle after the clock edge that consumes the last tick of a half-second. The bench therefore measures second lengths as the spacing between two strobes, sampled on falling edges, so the register stage cancels out. The halt flag rises on the STOP_TO-th clock edge that sees no tick. The bench checks it two edges before that point and two edges after it. After every change of trim or crystal select, the bench waits for a window boundary or a whole second before it measures, so no partial second is judged.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic {XTAL_32K768 = 1'b0, XTAL_32K000 = 1'b1} xtal_e;
endpackage

// File: rtl/tp_halt_det.sv
module tp_halt_det #(
  parameter int STOP_TO = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic clr_i,
  output logic halt_o
);
  localparam int IW = $clog2(STOP_TO);
  logic [IW-1:0] idle_q;
  logic          halt_q;
  logic          stop_det;

  assign stop_det = !osc_tick_i && (idle_q == IW'(STOP_TO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      halt_q <= 1'b1;
    end else begin
      if (osc_tick_i)    idle_q <= '0;
      else if (!stop_det) idle_q <= idle_q + IW'(1);
      halt_q <= stop_det | (halt_q & ~clr_i);
    end
  end

  assign halt_o = halt_q;

  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !clr_i |=> halt_q);
  p_halt_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_q) |-> !$past(osc_tick_i));
endmodule

// File: rtl/tp_window.sv
module tp_window #(
  parameter int WIN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_i,
  output logic corr_o
);
  localparam int WW = $clog2(WIN);
  logic [WW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (sec_i) idx_q <= (idx_q == WW'(WIN - 1)) ? '0 : idx_q + WW'(1);
  end

  assign corr_o = (idx_q == WW'(WIN - 1));

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < WIN);
  p_slot_leaves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o && sec_i |=> !corr_o);
endmodule

// File: rtl/tp_divider.sv
module tp_divider #(
  parameter int HALF_A = 16384,
  parameter int LO_B   = 15872,
  parameter int HI_B   = 16128,
  parameter int STEP   = 2,
  parameter int TRIM_W = 7,
  parameter int MAXLEN = 16512,
  parameter int CW     = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              corr_i,
  output logic              sec_o,
  output logic              half_o,
  output logic              phase_o
);
  logic [CW-1:0] cnt_q;
  logic          phase_q, half_q, sec_q, wrap;
  int            lo_len, hi_len, cur_len;

  always_comb begin
    lo_len  = sel_i ? LO_B : HALF_A;
    hi_len  = (sel_i ? HI_B : HALF_A) - (corr_i ? STEP * int'($signed(trim_i)) : 0);
    cur_len = phase_q ? hi_len : lo_len;
    // >= keeps the count bounded if the trim shrinks a half already in progress
    wrap    = tick_i && (int'(cnt_q) >= cur_len - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      half_q  <= 1'b0;
      sec_q   <= 1'b0;
    end else begin
      if (tick_i) begin
        if (wrap) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      half_q <= wrap;
      sec_q  <= wrap & phase_q;
    end
  end

  assign sec_o   = sec_q;
  assign half_o  = half_q;
  assign phase_o = phase_q;

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < MAXLEN);
  p_sec_on_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> half_q);
  p_sec_after_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> !phase_q);
  p_half_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |=> !half_q);
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler #(
  parameter int HALF_A  = 16384,
  parameter int LO_B    = 15872,
  parameter int HI_B    = 16128,
  parameter int WIN     = 20,
  parameter int TRIM_W  = 7,
  parameter int STEP    = 2,
  parameter int STOP_TO = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              xtal_sel_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              ctrl_wr_i,
  output logic              sec_o,
  output logic              hz2_o,
  output logic              hz1_o,
  output logic              win_o,
  output logic              halt_o
);
  import trim_pkg::*;

  localparam int NOM_MAX = (HALF_A > HI_B) ? HALF_A : HI_B;
  localparam int MAXLEN  = NOM_MAX + STEP * (2 ** (TRIM_W - 1));
  localparam int CW      = $clog2(MAXLEN + 1);

  logic              halt, corr;
  xtal_e             sel_eff;
  logic [TRIM_W-1:0] trim_eff;

  assign sel_eff  = halt ? XTAL_32K768 : xtal_e'(xtal_sel_i);
  assign trim_eff = halt ? '0 : trim_i;

  tp_halt_det #(.STOP_TO(STOP_TO)) u_halt (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i),
    .clr_i(ctrl_wr_i), .halt_o(halt)
  );

  tp_window #(.WIN(WIN)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_i(sec_o), .corr_o(corr)
  );

  tp_divider #(
    .HALF_A(HALF_A), .LO_B(LO_B), .HI_B(HI_B), .STEP(STEP),
    .TRIM_W(TRIM_W), .MAXLEN(MAXLEN), .CW(CW)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(osc_tick_i),
    .sel_i(sel_eff == XTAL_32K000), .trim_i(trim_eff), .corr_i(corr),
    .sec_o(sec_o), .half_o(hz2_o), .phase_o(hz1_o)
  );

  assign win_o  = corr;
  assign halt_o = halt;
endmodule

// File: tb/trim_prescaler_tb_top.sv
module trim_prescaler_tb_top;
  localparam int HALF_A = 256, LO_B = 248, HI_B = 252, WIN = 20;
  localparam int TRIM_W = 7, STEP = 2, STOP_TO = 64;

  logic clk = 0, rst_ni = 0, osc_tick = 1, sel = 0, wr = 0;
  logic [TRIM_W-1:0] trim = '0;
  logic sec, hz2, hz1, win, halt;
  bit   osc_en = 1;
  int   tick_div = 1;
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0, last_sec = 0, period = 0, sec_n = 0, halves = 0, half_cnt = 0;
  int   lo_run = 0, hi_run = 0, lo_len = 0, hi_len = 0;
  bit   sec_win = 0;

  always #10 clk = ~clk;

  trim_prescaler #(.HALF_A(HALF_A), .LO_B(LO_B), .HI_B(HI_B), .WIN(WIN),
    .TRIM_W(TRIM_W), .STEP(STEP), .STOP_TO(STOP_TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(osc_tick), .xtal_sel_i(sel),
    .trim_i(trim), .ctrl_wr_i(wr), .sec_o(sec), .hz2_o(hz2), .hz1_o(hz1),
    .win_o(win), .halt_o(halt));

  // oscillator tick generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
      osc_tick = osc_en && (ph == 0);
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (hz1) begin hi_run++; if (lo_run != 0) begin lo_len = lo_run; lo_run = 0; end end
      else     begin lo_run++; if (hi_run != 0) begin hi_len = hi_run; hi_run = 0; end end
      if (hz2) half_cnt++;
      if (sec) begin
        period = cyc - last_sec; last_sec = cyc; sec_win = win;
        halves = half_cnt; half_cnt = 0; sec_n++;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_sec();
    int s0 = sec_n;
    while (sec_n == s0) @(posedge clk);
  endtask

  task automatic wait_win();
    for (int i = 0; i < WIN + 2; i++) begin
      wait_sec();
      if (sec_win) break;
    end
  endtask

  task automatic pulse_wr();
    @(negedge clk); wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 halt", int'(halt), 1);
    chk("R1 sec", int'(sec), 0);
    chk("R1 hz2", int'(hz2), 0);
    chk("R1 hz1", int'(hz1), 0);
    chk("R1 win", int'(win), 0);
  endtask

  task automatic t_nominal();
    pulse_wr();
    chk("R8 clear", int'(halt), 0);
    wait_sec(); wait_sec();
    chk("R2 period", period, 2 * HALF_A);
    chk("R2 low half", lo_len, HALF_A);
    chk("R2 high half", hi_len, HALF_A);
    chk("R4 halves per second", halves, 2);
  endtask

  task automatic t_trim_pos();
    wait_win();
    chk("R6 zero trim", period, 2 * HALF_A);
    trim = 7'sd20;
    wait_win();
    chk("R5 slot flag", int'(sec_win), 1);
    chk("R6 positive trim", period, 2 * HALF_A - STEP * 20);
    wait_sec();
    chk("R7 next second", period, 2 * HALF_A);
    chk("R5 flag off", int'(sec_win), 0);
  endtask

  task automatic t_trim_neg();
    int cnt = 0;
    trim = -7'sd64;
    for (int i = 0; i < WIN; i++) begin
      wait_sec();
      if (sec_win) begin
        cnt++;
        chk("R6 negative trim", period, 2 * HALF_A + STEP * 64);
      end else begin
        chk("R7 unaffected", period, 2 * HALF_A);
      end
    end
    chk("R5 one slot per window", cnt, 1);
  endtask

  task automatic t_xtal_b();
    trim = '0; sel = 1;
    wait_sec(); wait_sec(); wait_sec();
    chk("R3 period", period, LO_B + HI_B);
    chk("R3 low", lo_len, LO_B);
    chk("R3 high", hi_len, HI_B);
  endtask

  task automatic t_rate();
    tick_div = 2;
    wait_sec(); wait_sec();
    chk("R10 scaled period", period, 2 * (LO_B + HI_B));
    tick_div = 1;
    wait_sec();
  endtask

  task automatic t_halt();
    trim = 7'sd30;
    @(negedge clk); osc_en = 0;
    repeat (STOP_TO - 2) @(posedge clk);
    @(negedge clk);
    chk("R8 before timeout", int'(halt), 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 after timeout", int'(halt), 1);
    osc_en = 1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R8 sticky", int'(halt), 1);
    wait_sec(); wait_sec();
    chk("R9 select forced", lo_len, HALF_A);
    wait_win();
    chk("R9 trim forced", period, 2 * HALF_A);
    pulse_wr();
    chk("R8 cleared by write", int'(halt), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_ni = 1;
    t_nominal();
    t_trim_pos();
    t_trim_neg();
    t_xtal_b();
    t_rate();
    t_halt();
    summary();
  end
endmodule